// File: doc/BRIEF.md
# Masked SIMD Lane Write Controller

This block manages how a packed vector operation on 64-bit elements obtains its operands and commits its destination. A request carries the source vector, the current destination value, a per-lane write mask and a set of control flags. The block latches the request, chooses how many lanes are active from a length code, and presents one operand per lane to an external lane function unit. Each operand is either the matching source element or, for a broadcast from memory, the lowest source element copied to every lane.

When the lane unit returns its results, the block builds the final destination. A lane takes its computed result when its mask bit is set or when masking is off. A masked-off lane either keeps its old destination value (merge) or is cleared (zero). Every bit above the active vector length is forced to zero. The destination is registered and announced with a one-cycle valid strobe.

Top module: `vec_lane_wctl`

## Requirements
- R1: The length code selects the active lanes: 0 gives lanes 0..1, 1 gives lanes 0..3, 2 and 3 give lanes 0..7. `op_lane_en` shows these lanes (0x03, 0x0F or 0xFF), and operand lanes outside them read as zero.
- R2: Without a memory broadcast, operand lane j equals source bits [64j+63:64j].
- R3: With `bcast` and `src_mem` both set, every active operand lane equals source bits [63:0].
- R4: With `bcast` set and `src_mem` clear, no broadcast takes place and operands follow R2.
- R5: With `mask_en` clear, every active destination lane takes the lane result, whatever the mask value.
- R6: With `mask_en` set, an active lane whose mask bit is 1 takes the lane result.
- R7: With `mask_en` set and `zero_mode` clear, an active lane whose mask bit is 0 keeps its old destination value.
- R8: With `mask_en` set and `zero_mode` set, an active lane whose mask bit is 0 becomes zero.
- R9: All destination bits from the active length up to bit 511 are zero.
- R10: Mask bits of lanes outside the active length have no effect on the destination.
- R11: `req_ready` is high only when idle. After a request is accepted, `op_valid` is high from the next cycle until `res_valid` is seen. The destination appears one cycle after that cycle, with `dst_valid` high for exactly one cycle.
- R12: After reset, `req_ready` is 1, `op_valid` and `dst_valid` are 0, and `dst_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Current destination value |
| mask | input | 8 | Per-lane write mask |
| len_sel | input | 2 | Vector length code (see R1) |
| bcast | input | 1 | Broadcast request |
| src_mem | input | 1 | Source comes from memory |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge |
| op_valid | output | 1 | Lane operands valid, waiting for results |
| op_lanes | output | 512 | Per-lane operands to the lane unit |
| op_lane_en | output | 8 | Active lane map |
| res_valid | input | 1 | Lane results present |
| res_vec | input | 512 | Lane results |
| dst_valid | output | 1 | Final destination strobe |
| dst_vec | output | 512 | Final destination |

## Verification
The main path is tried with every length code, with and without masking, in merge and zero mode, and with the broadcast flag paired with both memory and register sources. Source, old-destination and result lanes carry different values tagged with their lane index, so a wrong lane, a wrong source or a merge swapped for a zero shows up as a distinct value. Mask patterns set bits above the active length and clear bits inside it. This separates a block that honours out-of-range mask bits from one that ignores them, and it separates upper-bit clearing from masking. A delayed result checks that the operands stay presented and no destination leaks out early.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_256 = 2'd1,
    LEN_512 = 2'd2,
    LEN_RSV = 2'd3
  } vlen_e;

  typedef struct packed {
    vlen_e len;
    logic  bcast;
    logic  src_mem;
    logic  mask_en;
    logic  zero_mode;
  } vctl_t;

  // number of lanes active for a length code; the spare code acts as the widest
  function automatic int lanes_of(vlen_e l);
    case (l)
      LEN_128: return 2;
      LEN_256: return 4;
      default: return 8;
    endcase
  endfunction

  // a broadcast only happens for a memory source
  function automatic logic bcast_on(vctl_t c);
    return c.bcast & c.src_mem;
  endfunction

endpackage

// File: rtl/vlw_ctrl.sv
module vlw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic res_valid,
  output logic req_ready,
  output logic op_valid,
  output logic accept,
  output logic finish
);
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} st_e;
  st_e st_q, st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign op_valid  = (st_q == ST_BUSY);
  assign accept    = req_valid & req_ready;
  assign finish    = op_valid & res_valid;

  always_comb begin
    st_d = st_q;
    if (accept) st_d = ST_BUSY;
    else if (finish) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/vlw_operand_sel.sv
module vlw_operand_sel #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic [VEC_W-1:0]     src,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic                 bcast_active,
  output logic [VEC_W-1:0]     ops
);
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] pick;
    assign pick = bcast_active ? src[LANE_W-1:0] : src[j*LANE_W +: LANE_W];
    assign ops[j*LANE_W +: LANE_W] = lane_en[j] ? pick : '0;
  end
endmodule

// File: rtl/vlw_merge.sv
module vlw_merge #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic [VEC_W-1:0]     res,
  input  logic [VEC_W-1:0]     old,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic [MAX_LANES-1:0] mask,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  output logic [VEC_W-1:0]     dst
);
  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic take;
    logic [LANE_W-1:0] keep;
    assign take = ~mask_en | mask[j];
    assign keep = zero_mode ? '0 : old[j*LANE_W +: LANE_W];
    assign dst[j*LANE_W +: LANE_W] =
      !lane_en[j] ? '0 : (take ? res[j*LANE_W +: LANE_W] : keep);
  end
endmodule

// File: rtl/vec_lane_wctl.sv
module vec_lane_wctl #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VEC_W-1:0]     src_vec,
  input  logic [VEC_W-1:0]     old_dst,
  input  logic [MAX_LANES-1:0] mask,
  input  logic [1:0]           len_sel,
  input  logic                 bcast,
  input  logic                 src_mem,
  input  logic                 mask_en,
  input  logic                 zero_mode,
  output logic                 op_valid,
  output logic [VEC_W-1:0]     op_lanes,
  output logic [MAX_LANES-1:0] op_lane_en,
  input  logic                 res_valid,
  input  logic [VEC_W-1:0]     res_vec,
  output logic                 dst_valid,
  output logic [VEC_W-1:0]     dst_vec
);
  import vlw_pkg::*;

  logic                 accept, finish, bcast_active;
  vctl_t                ctl_q;
  logic [VEC_W-1:0]     src_q, old_q, dst_next, dst_q;
  logic [MAX_LANES-1:0] mask_q, lane_en;
  logic                 dst_valid_q;

  vlw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .res_valid(res_valid),
    .req_ready(req_ready), .op_valid(op_valid), .accept(accept), .finish(finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      src_q  <= '0;
      old_q  <= '0;
      mask_q <= '0;
    end else if (accept) begin
      ctl_q  <= '{len: vlen_e'(len_sel), bcast: bcast, src_mem: src_mem,
                 mask_en: mask_en, zero_mode: zero_mode};
      src_q  <= src_vec;
      old_q  <= old_dst;
      mask_q <= mask;
    end
  end

  always_comb begin
    for (int j = 0; j < MAX_LANES; j++) lane_en[j] = (j < lanes_of(ctl_q.len));
  end

  assign bcast_active = bcast_on(ctl_q);

  vlw_operand_sel #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_opsel (
    .src(src_q), .lane_en(lane_en), .bcast_active(bcast_active), .ops(op_lanes)
  );

  vlw_merge #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_merge (
    .res(res_vec), .old(old_q), .lane_en(lane_en), .mask(mask_q),
    .mask_en(ctl_q.mask_en), .zero_mode(ctl_q.zero_mode), .dst(dst_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q       <= '0;
      dst_valid_q <= 1'b0;
    end else begin
      dst_valid_q <= finish;
      if (finish) dst_q <= dst_next;
    end
  end

  assign op_lane_en = lane_en;
  assign dst_valid  = dst_valid_q;
  assign dst_vec    = dst_q;
endmodule

// File: rtl/vlw_checker.sv
module vlw_checker #(
  parameter int LANE_W    = 64,
  parameter int MAX_LANES = 8,
  localparam int VEC_W    = LANE_W * MAX_LANES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 op_valid,
  input logic                 res_valid,
  input logic                 dst_valid,
  input logic [MAX_LANES-1:0] op_lane_en,
  input logic [VEC_W-1:0]     op_lanes,
  input logic [VEC_W-1:0]     dst_vec,
  input logic                 bcast_active
);
  assert_lane_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_lane_en == MAX_LANES'(3) || op_lane_en == MAX_LANES'(15) ||
                  op_lane_en == MAX_LANES'(255)));

  assert_bcast_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && bcast_active) |-> (op_lanes[2*LANE_W-1:LANE_W] == op_lanes[LANE_W-1:0]));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !req_ready);

  assert_accept_to_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> op_valid);

  assert_finish_to_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && res_valid) |=> (dst_valid && !op_valid));

  assert_dst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> !dst_valid);

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_chk
    assert_idle_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_lane_en[j]) |-> (op_lanes[j*LANE_W +: LANE_W] == '0));
    assert_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !$past(op_lane_en[j])) |-> (dst_vec[j*LANE_W +: LANE_W] == '0));
  end
endmodule

bind vec_lane_wctl vlw_checker #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .op_valid(op_valid), .res_valid(res_valid), .dst_valid(dst_valid),
  .op_lane_en(op_lane_en), .op_lanes(op_lanes), .dst_vec(dst_vec),
  .bcast_active(bcast_active)
);

// File: tb/vec_lane_wctl_bench.sv
`timescale 1ns/1ps
module vec_lane_wctl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_ready;
  logic [511:0] src_vec = '0, old_dst = '0, op_lanes, res_vec = '0, dst_vec;
  logic [7:0]   mask = '0, op_lane_en;
  logic [1:0]   len_sel = '0;
  logic         bcast = 1'b0, src_mem = 1'b0, mask_en = 1'b0, zero_mode = 1'b0;
  logic         op_valid, res_valid = 1'b0, dst_valid;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  vec_lane_wctl u_vec_lane_wctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_vec(src_vec), .old_dst(old_dst), .mask(mask), .len_sel(len_sel),
    .bcast(bcast), .src_mem(src_mem), .mask_en(mask_en), .zero_mode(zero_mode),
    .op_valid(op_valid), .op_lanes(op_lanes), .op_lane_en(op_lane_en),
    .res_valid(res_valid), .res_vec(res_vec), .dst_valid(dst_valid), .dst_vec(dst_vec)
  );

  typedef struct packed {
    logic [1:0] len;
    logic       bc;
    logic       mem;
    logic       me;
    logic       zm;
    logic [7:0] mk;
    logic [3:0] seed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 4'h1},  // R5 R2 full width, mask ignored
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'h2},  // R1 R9 two lanes
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h3},  // R1 four lanes, memory no bcast
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 4'h4},  // R3 broadcast from memory
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'h5},  // R4 bcast flag with register
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 4'h6},  // R6 R7 merge
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 4'h7},  // R6 R8 zeroing
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFD, 4'h8},  // R10 upper bits set, merge
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF2, 4'h9},  // R10 upper bits set, zero
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'hA},  // R1 spare code = 8 lanes
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h02, 4'hB},  // R3 R8 bcast plus zeroing
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 4'hC}   // R3 R7 bcast plus merge
  };

  function automatic logic [63:0] src_lane(logic [3:0] s, int j);
    return {4'h1, s, 8'(j), 48'h0123_4567_89AB};
  endfunction
  function automatic logic [63:0] old_lane(logic [3:0] s, int j);
    return {4'hD, s, 8'(j), 48'hCAFE_0000_BEEF};
  endfunction
  function automatic logic [63:0] res_lane(logic [3:0] s, int j);
    return {4'h7, s, 8'(j), 48'h5555_AAAA_3333};
  endfunction
  function automatic int nlanes(logic [1:0] l);
    return (l == 2'd0) ? 2 : (l == 2'd1) ? 4 : 8;
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(vec_t v, int delay);
    logic [511:0] e_ops, e_dst;
    logic [7:0]   e_en;
    int n = nlanes(v.len);
    e_ops = '0; e_dst = '0; e_en = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < n) begin
        e_en[j] = 1'b1;
        e_ops[j*64 +: 64] = (v.bc && v.mem) ? src_lane(v.seed, 0) : src_lane(v.seed, j);
        if (!v.me || v.mk[j]) e_dst[j*64 +: 64] = res_lane(v.seed, j);
        else if (!v.zm)       e_dst[j*64 +: 64] = old_lane(v.seed, j);
      end
    end
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      src_vec[j*64 +: 64] = src_lane(v.seed, j);
      old_dst[j*64 +: 64] = old_lane(v.seed, j);
    end
    len_sel = v.len; bcast = v.bc; src_mem = v.mem; mask_en = v.me;
    zero_mode = v.zm; mask = v.mk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; src_vec = '0; old_dst = '0; mask = 8'h00;
    chk(op_valid && !req_ready, "R11 busy", {510'd0, op_valid, req_ready}, 512'd2);
    chk(op_lane_en == e_en, "R1 lane map", {504'd0, op_lane_en}, {504'd0, e_en});
    chk(op_lanes == e_ops, "R1/R2/R3/R4 operands", op_lanes, e_ops);
    repeat (delay) begin
      @(negedge clk);
      chk(op_valid && !dst_valid && op_lanes == e_ops, "R11 hold",
          op_lanes, e_ops);
    end
    for (int j = 0; j < 8; j++) res_vec[j*64 +: 64] = res_lane(v.seed, j);
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; res_vec = '1;
    chk(dst_valid && !op_valid, "R11 dst strobe", {510'd0, dst_valid, op_valid}, 512'd2);
    chk(dst_vec == e_dst, "R5-8 R9 R10 destination", dst_vec, e_dst);
    @(negedge clk);
    chk(!dst_valid && req_ready, "R11 single pulse", {510'd0, dst_valid, req_ready},
        512'd1);
    chk(dst_vec == e_dst, "R9 dst holds", dst_vec, e_dst);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready && !op_valid && !dst_valid, "R12 reset flags",
        {509'd0, req_ready, op_valid, dst_valid}, 512'd4);
    chk(dst_vec == '0, "R12 reset dst", dst_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !op_valid, "R12 after release", {510'd0, req_ready, op_valid},
        512'd2);
    for (int k = 0; k < NV; k++) run_op(TBL[k], 0);
    // R11 result arriving late: operands held, no early destination
    run_op('{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06, 4'hE}, 3);
    // R10 R7 every in-range lane masked off, out-of-range bits all set
    run_op('{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFC, 4'hF}, 1);
    // R11 res_valid while idle has no effect
    @(negedge clk);
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    chk(!dst_valid && req_ready, "R11 idle result ignored",
        {510'd0, dst_valid, req_ready}, 512'd1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule